// File: doc/BRIEF.md
# ADC Conversion Sequencer with Register Interface

This block lets software run one analog-to-digital conversion at a time on an eight-input, ten-bit converter through two 32-bit registers. The control/status word holds the channel to convert, the divider for the conversion clock, the interrupt enable, the reference choice and the module enable. It also holds a start bit that stays high while a conversion is running, and a completion flag. The second register returns the latched result.

The converter is reached through a plain digital port. The block supplies a one-cycle conversion-clock strobe, a request level, the channel number and the reference choice. It takes back a done pulse and the result. A done pulse only counts on a strobe cycle while a request is open. Software starts a conversion, then waits for the interrupt or polls the start bit. A start bit that never drops marks a converter that has stopped answering, and software recovers from it with the soft reset bit.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The control/status word is read and written at byte offset 0x00 and the result at offset 0x04. Writes to any other offset change nothing, and reads of other offsets return 0.
- R2: Control fields are read/write: channel in bits 27:24, interrupt enable in bit 21, reference select in bit 19 (1 = internal), module enable in bit 17 and divider in bits 8:1. All unused bits and bit 16 read as 0. The reference select bit drives `cnv_ref_int`.
- R3: While the module enable is 1, `cnv_tick` pulses once every 2*(divider+1) clock cycles. While the enable is 0, `cnv_tick` stays low.
- R4: A write to offset 0x00 with bit 13 = 1 and bit 17 = 1 starts a conversion when none is running. Bit 13 and `cnv_req` then read 1 from the next cycle on. A start written with bit 17 = 0 is ignored.
- R5: Bit 13 reads 1 for the whole conversion. Writing 0 or 1 to it during a conversion has no effect.
- R6: The channel is taken from the starting write. `cnv_chan` holds it until the conversion ends, even if bits 27:24 are rewritten in the meantime.
- R7: `cnv_done` is accepted only in a cycle where `cnv_req` and `cnv_tick` are both 1. On that clock edge the result is latched, bit 13 clears and the completion flag (bit 18) sets. All three changes are visible in the next cycle.
- R8: Writing 1 to bit 18 clears the completion flag, and writing 0 leaves it as it is. If a completion and a clearing write fall on the same edge, the flag ends up set.
- R9: `adc_irq` is 1 exactly while both the completion flag and the interrupt enable are 1.
- R10: Offset 0x04 returns the ten-bit result in bits 9:0, with bits 31:10 reading 0. Writes to this offset are ignored.
- R11: Writing 1 to bit 16 ends any conversion and clears bit 13, the completion flag and the result. The same write still stores the channel, divider, enables and reference fields. Any start bit in that write is ignored.
- R12: After reset, both registers read 0 and `adc_irq`, `cnv_req` and `cnv_tick` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| adc_irq | output | 1 | Completion interrupt |
| cnv_req | output | 1 | Conversion request, held while a conversion runs |
| cnv_chan | output | $clog2(NUM_CH) | Channel being converted |
| cnv_tick | output | 1 | Conversion-clock strobe |
| cnv_ref_int | output | 1 | 1 selects the internal reference |
| cnv_done | input | 1 | Converter completion pulse |
| cnv_data | input | RES_W | Converter result |

## Verification
The bench builds the block with its defaults: eight channels, a ten-bit result, an eight-bit divider field and an eight-bit offset. It then programs divider values 0, 1, 2, 3 and 7, so conversion-clock periods from 2 to 16 cycles are measured against the 2*(divider+1) rule. Short periods let one run cover several conversions. They also make possible the exact timing cases: a clearing write landing on the completion edge, a done pulse offered between strobes, and a soft reset during a long conversion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    // Control/status field positions (software decodes these)
    localparam int unsigned CH_LSB  = 24;
    localparam int unsigned CH_FW   = 4;
    localparam int unsigned IE_BIT  = 21;
    localparam int unsigned REF_BIT = 19;
    localparam int unsigned ST_BIT  = 18;
    localparam int unsigned EN_BIT  = 17;
    localparam int unsigned SR_BIT  = 16;
    localparam int unsigned GO_BIT  = 13;
    localparam int unsigned DIV_LSB = 1;

    localparam logic [7:0] OFF_CTRL = 8'h00;
    localparam logic [7:0] OFF_DATA = 8'h04;
endpackage

// File: rtl/adc_tick_gen.sv
module adc_tick_gen #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             restart_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    localparam int unsigned CW = DIV_W + 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tg_t;

    tg_t t_d, t_q;
    logic [CW-1:0] lim;
    logic          wrap;

    // Period of lim+1 = 2*(div+1); >= keeps a shrinking divider from overrunning
    assign lim  = {div_i, 1'b1};
    assign wrap = (t_q.cnt >= lim);

    always_comb begin
        t_d = t_q;
        if (!en_i || restart_i || wrap) begin
            t_d.cnt = '0;
        end else begin
            t_d.cnt = t_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign tick_o = en_i && wrap;
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
    parameter int unsigned CHS_W = 3,
    parameter int unsigned RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic             srst_i,
    input  logic             st_clr_i,
    input  logic [CHS_W-1:0] chan_i,
    input  logic             tick_i,
    input  logic             done_i,
    input  logic [RES_W-1:0] data_i,
    output logic             busy_o,
    output logic             stat_o,
    output logic [CHS_W-1:0] chan_o,
    output logic [RES_W-1:0] res_o
);
    typedef struct packed {
        logic             busy;
        logic             stat;
        logic [CHS_W-1:0] chan;
        logic [RES_W-1:0] res;
    } seq_t;

    seq_t s_d, s_q;
    logic fin;

    assign fin = s_q.busy && tick_i && done_i;

    always_comb begin
        s_d = s_q;
        if (srst_i) begin
            s_d.busy = 1'b0;
            s_d.stat = 1'b0;
            s_d.res  = '0;
        end else if (fin) begin
            // completion outranks a clearing write on the same edge
            s_d.busy = 1'b0;
            s_d.stat = 1'b1;
            s_d.res  = data_i;
        end else begin
            if (st_clr_i) begin
                s_d.stat = 1'b0;
            end
            if (go_i && !s_q.busy) begin
                s_d.busy = 1'b1;
                s_d.chan = chan_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o = s_q.busy;
    assign stat_o = s_q.stat;
    assign chan_o = s_q.chan;
    assign res_o  = s_q.res;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned RES_W  = 10,
    parameter int unsigned DIV_W  = 8,
    parameter int unsigned ADDR_W = 8,
    localparam int unsigned CHS_W = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              adc_irq,
    output logic              cnv_req,
    output logic [CHS_W-1:0]  cnv_chan,
    output logic              cnv_tick,
    output logic              cnv_ref_int,
    input  logic              cnv_done,
    input  logic [RES_W-1:0]  cnv_data
);
    typedef struct packed {
        logic [CH_FW-1:0] chan;
        logic             ie;
        logic             rsel;
        logic             en;
        logic [DIV_W-1:0] div;
    } ctl_t;

    ctl_t c_d, c_q;

    logic             wr_ctrl;
    logic             srst_req;
    logic             go_req;
    logic             st_clr;
    logic             busy;
    logic             stat;
    logic [RES_W-1:0] res;
    logic             unused_wbits;

    assign wr_ctrl  = reg_wr && (reg_addr == ADDR_W'(OFF_CTRL));
    assign srst_req = wr_ctrl && reg_wdata[SR_BIT];
    assign go_req   = wr_ctrl && reg_wdata[GO_BIT] && reg_wdata[EN_BIT];
    assign st_clr   = wr_ctrl && reg_wdata[ST_BIT];
    assign unused_wbits = ^reg_wdata;

    always_comb begin
        c_d = c_q;
        if (wr_ctrl) begin
            c_d.chan = reg_wdata[CH_LSB +: CH_FW];
            c_d.ie   = reg_wdata[IE_BIT];
            c_d.rsel = reg_wdata[REF_BIT];
            c_d.en   = reg_wdata[EN_BIT];
            c_d.div  = reg_wdata[DIV_LSB +: DIV_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    adc_tick_gen #(
        .DIV_W(DIV_W)
    ) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (c_q.en),
        .restart_i(srst_req),
        .div_i    (c_q.div),
        .tick_o   (cnv_tick)
    );

    adc_conv_seq #(
        .CHS_W(CHS_W),
        .RES_W(RES_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_i    (go_req),
        .srst_i  (srst_req),
        .st_clr_i(st_clr),
        .chan_i  (reg_wdata[CH_LSB +: CHS_W]),
        .tick_i  (cnv_tick),
        .done_i  (cnv_done),
        .data_i  (cnv_data),
        .busy_o  (busy),
        .stat_o  (stat),
        .chan_o  (cnv_chan),
        .res_o   (res)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(OFF_CTRL)) begin
            reg_rdata[CH_LSB +: CH_FW]  = c_q.chan;
            reg_rdata[IE_BIT]           = c_q.ie;
            reg_rdata[REF_BIT]          = c_q.rsel;
            reg_rdata[ST_BIT]           = stat;
            reg_rdata[EN_BIT]           = c_q.en;
            reg_rdata[GO_BIT]           = busy;
            reg_rdata[DIV_LSB +: DIV_W] = c_q.div;
        end else if (reg_addr == ADDR_W'(OFF_DATA)) begin
            reg_rdata[RES_W-1:0] = res;
        end
    end

    assign adc_irq     = stat && c_q.ie;
    assign cnv_req     = busy;
    assign cnv_ref_int = c_q.rsel;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk
    import adc_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned CHS_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              adc_irq,
    input logic              cnv_req,
    input logic [CHS_W-1:0]  cnv_chan,
    input logic              cnv_tick,
    input logic              cnv_done,
    input logic              en_i,
    input logic              ie_i
);
    logic wc;
    logic unused_wbits;
    assign wc = reg_wr && (reg_addr == ADDR_W'(OFF_CTRL));
    assign unused_wbits = ^reg_wdata;

    // R3: no conversion-clock strobe while the module is disabled
    a_r3_no_tick_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> !cnv_tick);

    // R4: a request only opens after a start write carrying the enable
    a_r4_start_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnv_req) |-> $past(wc && reg_wdata[GO_BIT] && reg_wdata[EN_BIT]));

    // R6: channel stays put during a conversion
    a_r6_chan_held: assert property (@(posedge clk) disable iff (!rst_n)
        (cnv_req && $past(cnv_req)) |-> $stable(cnv_chan));

    // R7 / R11: a request closes only on an accepted done or a soft reset
    a_r7_req_ends_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cnv_req) |-> ($past(cnv_tick && cnv_done) || $past(wc && reg_wdata[SR_BIT])));

    // R9: interrupt never raised with interrupts disabled
    a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        adc_irq |-> ie_i);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(
    .ADDR_W(ADDR_W),
    .CHS_W (CHS_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .adc_irq  (adc_irq),
    .cnv_req  (cnv_req),
    .cnv_chan (cnv_chan),
    .cnv_tick (cnv_tick),
    .cnv_done (cnv_done),
    .en_i     (c_q.en),
    .ie_i     (c_q.ie)
);

// File: tb/tb_adc_seq_ctrl.sv
`timescale 1ns/1ps
module tb_adc_seq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        adc_irq, cnv_req, cnv_tick, cnv_ref_int;
    logic [2:0]  cnv_chan;
    logic        cnv_done = 1'b0;
    logic [9:0]  cnv_data = 10'h0;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    adc_seq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .adc_irq(adc_irq),
        .cnv_req(cnv_req), .cnv_chan(cnv_chan), .cnv_tick(cnv_tick),
        .cnv_ref_int(cnv_ref_int), .cnv_done(cnv_done), .cnv_data(cnv_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ctl(input int ch, input bit ie, input bit rs, input bit st,
                                        input bit en, input bit sr, input bit go, input int dv);
        return (32'(ch) << 24) | (32'(ie) << 21) | (32'(rs) << 19) | (32'(st) << 18) |
               (32'(en) << 17) | (32'(sr) << 16) | (32'(go) << 13) | (32'(dv & 8'hff) << 1);
    endfunction

    // ---------------- converter stand-in ----------------
    int  lat = 0;
    bit  glitch = 1'b0;
    logic [6:0] seed = 7'h0;
    always @(posedge clk) begin
        int tcnt;
        #0.5;
        cnv_data = {cnv_chan, seed};
        if (!cnv_req) begin
            tcnt = 0;
            cnv_done = 1'b0;
        end else if (cnv_tick) begin
            if (tcnt >= lat) cnv_done = 1'b1;
            else begin
                cnv_done = 1'b0;
                tcnt++;
            end
        end else begin
            cnv_done = glitch;
        end
    end

    // ---------------- behavioural reference, compared each cycle ----------------
    bit         m_busy, m_st, m_ie, m_rs, m_en;
    logic [3:0] m_ch;
    logic [7:0] m_div;
    logic [2:0] m_cc;
    logic [9:0] m_res;
    int cyc = 0, last_tick = 0;
    bit per_ok = 1'b0;

    function automatic logic [31:0] m_ctrl();
        return ctl(m_ch, m_ie, m_rs, m_st, m_en, 1'b0, m_busy, m_div);
    endfunction

    always @(negedge clk) begin
        logic [31:0] e;
        bit wc, fin;
        if (!rst_n) begin
            {m_busy, m_st, m_ie, m_rs, m_en} = '0;
            m_ch = '0; m_div = '0; m_cc = '0; m_res = '0;
            per_ok = 1'b0;
        end else begin
            cyc++;
            if (reg_addr == 8'h00) begin
                e = m_ctrl();
                chk(reg_rdata == e, "R2 ctrl readback", reg_rdata, e);
            end else if (reg_addr == 8'h04) begin
                e = {22'h0, m_res};
                chk(reg_rdata == e, "R10 data readback", reg_rdata, e);
            end else begin
                chk(reg_rdata == 32'h0, "R1 unmapped read", reg_rdata, 32'h0);
            end
            chk(adc_irq == (m_st && m_ie), "R9 irq level", 32'(adc_irq), 32'(m_st && m_ie));
            chk(cnv_req == m_busy, "R4 request level", 32'(cnv_req), 32'(m_busy));
            if (m_busy) chk(cnv_chan == m_cc, "R6 converted channel", 32'(cnv_chan), 32'(m_cc));
            chk(cnv_ref_int == m_rs, "R2 reference output", 32'(cnv_ref_int), 32'(m_rs));
            if (cnv_tick) begin
                chk(m_en, "R3 tick while disabled", 32'(cnv_tick), 32'h0);
                if (per_ok) chk(cyc - last_tick == 2 * (int'(m_div) + 1), "R3 tick period",
                                32'(cyc - last_tick), 32'(2 * (int'(m_div) + 1)));
                last_tick = cyc;
                per_ok = 1'b1;
            end

            wc  = reg_wr && reg_addr == 8'h00;
            fin = m_busy && cnv_tick && cnv_done;
            if (wc) per_ok = 1'b0;
            if (wc && reg_wdata[16]) begin
                m_busy = 1'b0; m_st = 1'b0; m_res = '0;
            end else if (fin) begin
                m_busy = 1'b0; m_st = 1'b1; m_res = cnv_data;
            end else begin
                if (wc && reg_wdata[18]) m_st = 1'b0;
                if (wc && reg_wdata[13] && reg_wdata[17] && !m_busy) begin
                    m_busy = 1'b1;
                    m_cc = reg_wdata[26:24];
                end
            end
            if (wc) begin
                m_ch = reg_wdata[27:24]; m_ie = reg_wdata[21]; m_rs = reg_wdata[19];
                m_en = reg_wdata[17];    m_div = reg_wdata[8:1];
            end
            if (!m_en) per_ok = 1'b0;
        end
    end

    // ---------------- stimulus helpers (called at posedge + 1 ns) ----------------
    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(posedge clk); #1;
        reg_wr = 1'b0; reg_wdata = 32'h0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        reg_addr = a;
        @(negedge clk);
        v = reg_rdata;
        @(posedge clk); #1;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 400; i++) begin
            rd(8'h00, v);
            if (!v[13]) return;
        end
        chk(1'b0, "R7 conversion never finished", 32'h1, 32'h0);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int ntick;
        bit hit;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R12 reset state
        rd(8'h00, v); chk(v == 0, "R12 ctrl after reset", v, 0);
        rd(8'h04, v); chk(v == 0, "R12 data after reset", v, 0);
        chk(!adc_irq && !cnv_req && !cnv_tick, "R12 outputs after reset", {adc_irq, cnv_req, cnv_tick}, 0);

        // R2 field readback, R1 map
        wr(8'h00, ctl(5, 1, 1, 0, 1, 0, 0, 2));
        rd(8'h00, v); chk(v == 32'h052A0004, "R2 fields", v, 32'h052A0004);
        chk(cnv_ref_int == 1'b1, "R2 reference select", 32'(cnv_ref_int), 1);
        wr(8'h08, 32'hFFFFFFFF);
        rd(8'h08, v); chk(v == 0, "R1 unmapped offset", v, 0);
        rd(8'h00, v); chk(v == 32'h052A0004, "R1 unmapped write no effect", v, 32'h052A0004);
        wr(8'h04, 32'hFFFFFFFF);
        rd(8'h04, v); chk(v == 0, "R10 data write ignored", v, 0);
        idle(30);

        // R4 start ignored while disabled, R3 no ticks
        wr(8'h00, ctl(1, 1, 0, 0, 0, 0, 1, 2));
        rd(8'h00, v); chk(v[13] == 1'b0, "R4 start with enable 0", 32'(v[13]), 0);
        ntick = 0;
        repeat (20) begin if (cnv_tick) ntick++; idle(1); end
        chk(ntick == 0 && !cnv_req, "R3 no ticks while disabled", ntick, 0);

        // R4/R5/R6/R7 normal conversion
        lat = 2; seed = 7'h55;
        wr(8'h00, ctl(3, 1, 0, 0, 1, 0, 1, 2));
        rd(8'h00, v); chk(v[13] == 1'b1 && cnv_req, "R5 start bit set", 32'(v[13]), 1);
        chk(cnv_chan == 3'd3, "R6 channel latched", 32'(cnv_chan), 3);
        wr(8'h00, ctl(6, 1, 0, 0, 1, 0, 0, 2));
        rd(8'h00, v); chk(v[13] == 1'b1, "R5 write 0 during busy", 32'(v[13]), 1);
        chk(v[27:24] == 4'd6 && cnv_chan == 3'd3, "R6 rewrite during busy", 32'(cnv_chan), 3);
        wait_idle();
        rd(8'h04, v); chk(v == {22'h0, 3'd3, 7'h55}, "R7 result latched", v, {22'h0, 3'd3, 7'h55});
        rd(8'h00, v); chk(v[18] == 1'b1, "R7 status set", 32'(v[18]), 1);
        chk(adc_irq == 1'b1, "R9 irq on completion", 32'(adc_irq), 1);

        // R8 write-one-to-clear
        wr(8'h00, ctl(6, 1, 0, 0, 1, 0, 0, 2));
        rd(8'h00, v); chk(v[18] == 1'b1, "R8 write 0 keeps flag", 32'(v[18]), 1);
        wr(8'h00, ctl(6, 1, 0, 1, 1, 0, 0, 2));
        rd(8'h00, v); chk(v[18] == 1'b0 && !adc_irq, "R8 write 1 clears flag", 32'(v[18]), 0);

        // R9 interrupt gated by enable, divider 0
        lat = 0; seed = 7'h2A;
        wr(8'h00, ctl(7, 0, 0, 0, 1, 0, 1, 0));
        wait_idle();
        rd(8'h00, v); chk(v[18] == 1'b1 && !adc_irq, "R9 no irq when disabled", 32'(adc_irq), 0);
        rd(8'h04, v); chk(v == {22'h0, 3'd7, 7'h2A}, "R10 result bits", v, {22'h0, 3'd7, 7'h2A});
        wr(8'h00, ctl(7, 1, 0, 0, 1, 0, 0, 0));
        rd(8'h00, v); chk(adc_irq == 1'b1, "R9 irq after enabling", 32'(adc_irq), 1);

        // R7 done ignored off the strobe
        lat = 1; glitch = 1'b1; seed = 7'h11;
        wr(8'h00, ctl(2, 1, 0, 1, 1, 0, 1, 3));
        idle(2);
        rd(8'h00, v); chk(v[13] == 1'b1, "R7 off-strobe done ignored", 32'(v[13]), 1);
        wait_idle();
        glitch = 1'b0;
        rd(8'h04, v); chk(v == {22'h0, 3'd2, 7'h11}, "R7 result after glitches", v, {22'h0, 3'd2, 7'h11});

        // R11 soft reset during a long conversion
        lat = 20;
        wr(8'h00, ctl(4, 1, 0, 0, 1, 0, 1, 7));
        idle(5);
        wr(8'h00, ctl(2, 1, 0, 0, 1, 1, 1, 1));
        rd(8'h00, v); chk(v == 32'h02220002, "R11 soft reset ctrl", v, 32'h02220002);
        rd(8'h04, v); chk(v == 0, "R11 soft reset result", v, 0);
        chk(!cnv_req && !adc_irq, "R11 soft reset outputs", {cnv_req, adc_irq}, 0);
        idle(20);
        lat = 0; seed = 7'h3C;
        wr(8'h00, ctl(1, 1, 0, 0, 1, 0, 1, 1));
        wait_idle();
        rd(8'h04, v); chk(v == {22'h0, 3'd1, 7'h3C}, "R11 conversion after soft reset", v, {22'h0, 3'd1, 7'h3C});

        // R8 set wins over a clear on the completion edge
        wr(8'h00, ctl(5, 1, 0, 1, 1, 0, 0, 0));
        lat = 1; seed = 7'h07;
        wr(8'h00, ctl(5, 1, 0, 0, 1, 0, 1, 0));
        hit = 1'b0;
        for (int i = 0; i < 100 && !hit; i++) begin
            if (cnv_done && cnv_tick) begin
                wr(8'h00, ctl(5, 1, 0, 1, 1, 0, 0, 0));
                hit = 1'b1;
            end else idle(1);
        end
        rd(8'h00, v); chk(hit && v[18] == 1'b1, "R8 set beats clear", 32'(v[18]), 1);

        idle(5);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule